// File: doc/BRIEF.md
# Aligned SPI Block-Transfer Sequencer

This block is the master side of a serial link into a remote memory space. A request names a direction, a 32-bit start address and a byte count. The engine splits the request into a chain of SPI commands. Each command moves 2 bytes, 4 bytes, or a whole number of 8-byte words, and its address is always naturally aligned for its size. The choice for each chunk comes from the low three address bits and the bytes still to move, so the chain is as short as the alignment allows. For example, a 260-byte read starting at an address whose low bits are 2 becomes chunks of 2, 4, 240, 8, 4 and 2 bytes.

Each command is one chip-select window. The window opens with a command byte and then the chunk address, most significant byte first. A read follows this with four idle bytes and then clocks data in. A write sends its data and then one idle byte. On the wire, the bytes of each word go in reverse order. The word is the chunk itself for 2- and 4-byte chunks and 8 bytes inside a burst. Local data moves through two byte streams with valid/ready. Write data is pulled from `wd_*` and read data is pushed out on `rd_*`. While either stream stalls, the engine holds the serial clock low, so back-pressure simply stretches the transfer. When the request is unaligned the engine reports an error without touching the bus. When a write has an odd length, the engine pads it with a zero byte.

Top module: `spi_chunk_xfer`

## Requirements
- R1: The command byte is `{5'b0, size, wr}`, where size is 0 for a 2-byte chunk, 1 for a 4-byte chunk and 2 for a burst, and wr is 1 for a write. The codes are therefore 0x0/0x1 for 2-byte reads and writes, 0x2/0x3 for 4-byte, and 0x4/0x5 for burst.
- R2: The chunk is picked from the address low three bits (A) and the bytes left (N), checking the rules in this order. If A is 2 or 6, or N equals 2, the chunk is 2 bytes. Otherwise, if A is 4 or N is at most 6, the chunk is 4 bytes. Otherwise the chunk is a burst of N rounded down to a multiple of 8, capped at BURST_MAX (240).
- R3: Each command sends the command byte, then the 32-bit chunk address most significant byte first. Every byte goes MSB first in SPI mode 0: the clock idles low, MOSI changes only while the clock is low, and MISO is sampled on the rising edge. The chunk address starts at the request address and grows by each chunk's length.
- R4: A read sends four 0x00 bytes after the address and then clocks in the chunk's data bytes while driving MOSI low.
- R5: A write sends the chunk's data bytes after the address, followed by one 0x00 byte.
- R6: On the wire, bytes are reversed within each word. The word size is the smaller of the chunk length and 8. So buffer bytes b0..b3 of a 4-byte chunk go out as b3,b2,b1,b0.
- R7: Chip select is low for exactly one whole command and goes high for at least one cycle between commands. The serial clock is low whenever chip select is high.
- R8: An odd start address, or a read with an odd length, ends the request with `error` high during the `done` pulse. No chip-select activity occurs in that case.
- R9: A write with an odd length sends one extra zero byte at the end. Exactly the requested number of bytes is taken from the write stream.
- R10: `start` is taken only while idle. `busy` is high from the next cycle until `done` has pulsed for one cycle. A zero-length request pulses `done` with no bus activity.
- R11: Stream bytes move only on cycles where valid and ready are both high. `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low. Read data leaves in buffer order, with byte i coming from request address + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 32 | Start byte address |
| req_len | input | LEN_W | Byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Alignment failure, valid with done |
| wd_data | input | 8 | Write stream byte |
| wd_valid | input | 1 | Write stream byte present |
| wd_ready | output | 1 | Engine takes the write byte |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte present |
| rd_ready | input | 1 | Consumer takes the read byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench aims at four kinds of corner case. The first is the alignment walk. A start at address low bits 2 must produce the 2, 4, 240, 8, 4, 2 chunk chain; an engine that ranked the rules differently would emit a burst at a 2-aligned address, or more commands than needed. The second is word reversal. A remote memory model only stores the right bytes when the 8-byte burst word and the shorter words are each mirrored; a design that mirrored the whole chunk, or nothing, would scramble the stored data. The third is odd lengths. A write of 3 or 7 bytes must leave a zero just past the end and must take no extra stream byte, while an odd read or an odd address must raise `error` with chip select left high. The fourth is stall behaviour. Gaps on the write stream and a read consumer that drops `rd_ready` every third cycle check that a stalled read byte stays put and that no byte is lost or repeated.

// File: rtl/spi_chunk_pkg.sv
package spi_chunk_pkg;

  typedef enum logic [1:0] {
    SZ_HALF  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_BURST = 2'd2
  } chunk_size_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PICK,
    S_HDR,
    S_DUMMY,
    S_LOAD,
    S_SEND,
    S_RECV,
    S_UNLOAD,
    S_TRAIL,
    S_GAP,
    S_FIN
  } seq_state_e;

endpackage

// File: rtl/chunk_pick.sv
module chunk_pick
  import spi_chunk_pkg::*;
#(
  parameter int RW        = 17,
  parameter int BURST_MAX = 240
) (
  input  logic [2:0]    align,
  input  logic [RW-1:0] remain,
  output chunk_size_e   size,
  output logic [7:0]    clen,
  output logic [3:0]    wsz
);
  logic [RW-1:0] rounded;

  always_comb begin
    rounded = {remain[RW-1:3], 3'b000};
    if (align == 3'd2 || align == 3'd6 || remain == RW'(2)) begin
      size = SZ_HALF;
      clen = 8'd2;
    end else if (align == 3'd4 || remain <= RW'(6)) begin
      size = SZ_WORD;
      clen = 8'd4;
    end else begin
      size = SZ_BURST;
      clen = (rounded > RW'(BURST_MAX)) ? 8'(BURST_MAX) : rounded[7:0];
    end
    wsz = (clen > 8'd8) ? 4'd8 : clen[3:0];
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic          active, high;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sreg, rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      high   <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sreg   <= '0;
      rxs    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          high   <= 1'b0;
          cnt    <= '0;
          bitn   <= '0;
          sreg   <= tx_byte;
        end
      end else if (cnt == CW'(HALF - 1)) begin
        cnt <= '0;
        if (!high) begin
          high <= 1'b1;
          rxs  <= {rxs[6:0], miso};
        end else begin
          high <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sreg <= {sreg[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign sclk    = active & high;
  assign mosi    = active & sreg[7];
  assign rx_byte = rxs;

  // R3
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
endmodule

// File: rtl/spi_chunk_xfer.sv
module spi_chunk_xfer
  import spi_chunk_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int BURST_MAX   = 240,
  parameter int HALF_PERIOD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_write,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             error,
  input  logic [7:0]       wd_data,
  input  logic             wd_valid,
  output logic             wd_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int RW = LEN_W + 1;

  seq_state_e       state;
  logic             wr_q, err_q, pend_q;
  logic [31:0]      addr_q;
  logic [RW-1:0]    remain_q;
  logic [LEN_W-1:0] real_left_q;
  chunk_size_e      size_q;
  logic [7:0]       clen_q, cleft_q;
  logic [3:0]       wsz_q, idx_q;
  logic [7:0]       wbuf [8];

  chunk_size_e pk_size;
  logic [7:0]  pk_clen;
  logic [3:0]  pk_wsz;

  chunk_pick #(.RW(RW), .BURST_MAX(BURST_MAX)) u_pick (
    .align (addr_q[2:0]),
    .remain(remain_q),
    .size  (pk_size),
    .clen  (pk_clen),
    .wsz   (pk_wsz)
  );

  logic       sh_go, sh_done;
  logic [7:0] sh_tx, sh_rx, hdr_byte;
  logic [3:0] ridx;
  logic       last_in_word, last_word, load_step, bad_req;

  spi_byte_shift #(.HALF(HALF_PERIOD)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (sh_go),
    .tx_byte(sh_tx),
    .done   (sh_done),
    .rx_byte(sh_rx),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .miso   (spi_miso)
  );

  always_comb begin
    case (idx_q)
      4'd0:    hdr_byte = {5'd0, 2'(size_q), wr_q};
      4'd1:    hdr_byte = addr_q[31:24];
      4'd2:    hdr_byte = addr_q[23:16];
      4'd3:    hdr_byte = addr_q[15:8];
      default: hdr_byte = addr_q[7:0];
    endcase
    ridx         = wsz_q - 4'd1 - idx_q;
    last_in_word = (idx_q == wsz_q - 4'd1);
    last_word    = (cleft_q == {4'd0, wsz_q});
    load_step    = (real_left_q == '0) || wd_valid;
    bad_req      = req_addr[0] | (~req_write & req_len[0]);
    sh_go = !pend_q && (state == S_HDR || state == S_DUMMY || state == S_SEND ||
                        state == S_RECV || state == S_TRAIL);
    case (state)
      S_HDR:   sh_tx = hdr_byte;
      S_SEND:  sh_tx = wbuf[ridx[2:0]];
      default: sh_tx = 8'h00;
    endcase
  end

  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);
  assign error    = done & err_q;
  assign wd_ready = (state == S_LOAD) && (real_left_q != '0);
  assign rd_valid = (state == S_UNLOAD);
  assign rd_data  = wbuf[ridx[2:0]];
  assign spi_cs_n = !(state == S_HDR || state == S_DUMMY || state == S_LOAD ||
                      state == S_SEND || state == S_RECV || state == S_UNLOAD ||
                      state == S_TRAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      wr_q        <= 1'b0;
      err_q       <= 1'b0;
      pend_q      <= 1'b0;
      addr_q      <= '0;
      remain_q    <= '0;
      real_left_q <= '0;
      size_q      <= SZ_HALF;
      clen_q      <= '0;
      cleft_q     <= '0;
      wsz_q       <= '0;
      idx_q       <= '0;
      for (int i = 0; i < 8; i++) wbuf[i] <= '0;
    end else begin
      if (sh_go) pend_q <= 1'b1;
      else if (sh_done) pend_q <= 1'b0;

      case (state)
        S_IDLE: if (start) begin
          wr_q        <= req_write;
          addr_q      <= req_addr;
          real_left_q <= req_len;
          remain_q    <= {1'b0, req_len} + RW'(req_write & req_len[0]);
          err_q       <= bad_req;
          if (bad_req || req_len == '0) state <= S_FIN;
          else state <= S_PICK;
        end
        S_PICK: begin
          size_q  <= pk_size;
          clen_q  <= pk_clen;
          cleft_q <= pk_clen;
          wsz_q   <= pk_wsz;
          idx_q   <= '0;
          state   <= S_HDR;
        end
        S_HDR: if (sh_done) begin
          if (idx_q == 4'd4) begin
            idx_q <= '0;
            state <= wr_q ? S_LOAD : S_DUMMY;
          end else idx_q <= idx_q + 4'd1;
        end
        S_DUMMY: if (sh_done) begin
          if (idx_q == 4'd3) begin
            idx_q <= '0;
            state <= S_RECV;
          end else idx_q <= idx_q + 4'd1;
        end
        S_LOAD: if (load_step) begin
          if (real_left_q != '0) begin
            wbuf[idx_q[2:0]] <= wd_data;
            real_left_q      <= real_left_q - LEN_W'(1);
          end else wbuf[idx_q[2:0]] <= 8'h00;
          if (last_in_word) begin
            idx_q <= '0;
            state <= S_SEND;
          end else idx_q <= idx_q + 4'd1;
        end
        S_SEND: if (sh_done) begin
          if (last_in_word) begin
            idx_q   <= '0;
            cleft_q <= cleft_q - {4'd0, wsz_q};
            state   <= last_word ? S_TRAIL : S_LOAD;
          end else idx_q <= idx_q + 4'd1;
        end
        S_TRAIL: if (sh_done) begin
          addr_q   <= addr_q + {24'd0, clen_q};
          remain_q <= remain_q - RW'(clen_q);
          state    <= S_GAP;
        end
        S_RECV: if (sh_done) begin
          wbuf[idx_q[2:0]] <= sh_rx;
          if (last_in_word) begin
            idx_q <= '0;
            state <= S_UNLOAD;
          end else idx_q <= idx_q + 4'd1;
        end
        S_UNLOAD: if (rd_ready) begin
          if (last_in_word) begin
            idx_q   <= '0;
            cleft_q <= cleft_q - {4'd0, wsz_q};
            if (last_word) begin
              addr_q   <= addr_q + {24'd0, clen_q};
              remain_q <= remain_q - RW'(clen_q);
              state    <= S_GAP;
            end else state <= S_RECV;
          end else idx_q <= idx_q + 4'd1;
        end
        S_GAP:   state <= (remain_q == '0) ? S_FIN : S_PICK;
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  cs_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && busy) |-> spi_cs_n);
  // R2
  burst_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && clen_q >= 8'd8) |->
      (addr_q[2:0] == 3'd0 && clen_q[2:0] == 3'd0 && clen_q <= 8'(BURST_MAX)));
  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && clen_q == 8'd4) |-> (addr_q[1:0] == 2'd0));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R9
  wd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> (wr_q && busy && !err_q));
endmodule

// File: tb/tb_spi_chunk_xfer.sv
module tb_spi_chunk_xfer;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, req_write, busy, done, error;
  logic [31:0] req_addr;
  logic [LEN_W-1:0] req_len;
  logic [7:0] wd_data, rd_data;
  logic wd_valid, wd_ready, rd_valid, rd_ready;
  logic spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  spi_chunk_xfer #(.LEN_W(LEN_W), .BURST_MAX(240), .HALF_PERIOD(2)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
    .error(error), .wd_data(wd_data), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] txpat(input int v, input int i);
    return 8'(i * 37 + v * 11 + 5);
  endfunction

  // remote memory model on the serial side
  logic [7:0] mem [0:1023];
  logic [7:0] frame [0:255];
  int bi = 0, bc = 0, nframes = 0;
  logic [7:0] sh = 8'h00;
  logic [7:0] log_cmd [0:15];
  logic [31:0] log_addr [0:15];
  int log_len [0:15];
  bit log_zok [0:15];
  int last_bi = 0;

  always @(negedge spi_cs_n) begin
    bi = 0;
    bc = 0;
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    bc++;
    if (bc == 8) begin
      if (bi < 256) frame[bi] = sh;
      bi++;
      bc = 0;
    end
  end

  always @(posedge spi_cs_n) if (bi >= 5) begin
    automatic int k = nframes % 16;
    automatic logic [31:0] a = {frame[1], frame[2], frame[3], frame[4]};
    automatic int ws = (frame[0][2:1] == 2'd0) ? 2 : (frame[0][2:1] == 2'd1) ? 4 : 8;
    automatic bit zok = 1'b1;
    automatic int nd;
    log_cmd[k] = frame[0];
    log_addr[k] = a;
    last_bi = bi;
    if (frame[0][0]) begin
      nd = bi - 6;
      if (frame[bi-1] != 8'h00) zok = 1'b0;
      for (int j = 0; j < nd; j++)
        mem[10'(a + 32'(j - j % ws + ws - 1 - j % ws))] = frame[5 + j];
    end else begin
      nd = bi - 9;
      for (int j = 5; j < bi; j++) if (frame[j] != 8'h00) zok = 1'b0;
    end
    log_len[k] = nd;
    log_zok[k] = zok;
    nframes++;
  end

  int rj, rws;
  logic [9:0] ridx;
  logic [7:0] rbyte;
  always_comb begin
    rj = bi - 9;
    rws = (frame[0][2:1] == 2'd0) ? 2 : (frame[0][2:1] == 2'd1) ? 4 : 8;
    ridx = '0;
    rbyte = 8'h00;
    if (!spi_cs_n && bi >= 9 && !frame[0][0]) begin
      ridx = 10'({frame[3], frame[4]} + 16'(rj - rj % rws + rws - 1 - rj % rws));
      rbyte = mem[ridx];
    end
    spi_miso = rbyte[3'(7 - bc)];
  end

  // request runner
  logic [7:0] rxcap [0:1023];
  int r_err, r_rc, r_ti, r_f0;

  task automatic run(input bit wr, input int a, input int len, input int vid);
    automatic int cyc = 0;
    automatic bit hold = 1'b0;
    automatic logic [7:0] hold_data = 8'h00;
    r_ti = 0;
    r_rc = 0;
    r_err = 0;
    @(negedge clk);
    req_write = wr;
    req_addr = 32'(a);
    req_len = LEN_W'(len);
    start = 1'b1;
    r_f0 = nframes;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "busy after start", busy, 1);
    forever begin
      wd_valid = wr && (r_ti < len) && (cyc % 5 != 3);
      wd_data = txpat(vid, r_ti);
      rd_ready = (cyc % 3 != 1);
      #1;
      if (wd_valid && wd_ready) r_ti++;
      if (hold) check(rd_valid && rd_data == hold_data, "R11", "stalled read byte held",
                      rd_data, hold_data);
      hold = 1'b0;
      if (rd_valid) begin
        if (rd_ready) begin
          rxcap[r_rc % 1024] = rd_data;
          r_rc++;
        end else begin
          hold = 1'b1;
          hold_data = rd_data;
        end
      end
      if (done) begin
        r_err = int'(error);
        break;
      end
      @(negedge clk);
      cyc++;
    end
    wd_valid = 1'b0;
    rd_ready = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R10", "idle after done", busy, 0);
  endtask

  // wr, addr[11:0], len[11:0], command count, error
  localparam logic [33:0] VEC [0:12] = '{
    {1'b0, 12'h002, 12'd260, 8'd6, 1'b0},
    {1'b1, 12'h002, 12'd260, 8'd6, 1'b0},
    {1'b1, 12'h100, 12'd16,  8'd1, 1'b0},
    {1'b1, 12'h105, 12'd4,   8'd0, 1'b1},
    {1'b0, 12'h040, 12'd7,   8'd0, 1'b1},
    {1'b1, 12'h060, 12'd7,   8'd1, 1'b0},
    {1'b0, 12'h006, 12'd2,   8'd1, 1'b0},
    {1'b1, 12'h004, 12'd4,   8'd1, 1'b0},
    {1'b1, 12'h200, 12'd500, 8'd4, 1'b0},
    {1'b0, 12'h200, 12'd500, 8'd4, 1'b0},
    {1'b1, 12'h00A, 12'd3,   8'd2, 1'b0},
    {1'b0, 12'h000, 12'd0,   8'd0, 1'b0},
    {1'b0, 12'h300, 12'd6,   8'd2, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 3 + 1);
    rst_n = 1'b0;
    start = 1'b0;
    req_write = 1'b0;
    req_addr = '0;
    req_len = '0;
    wd_data = '0;
    wd_valid = 1'b0;
    rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !error, "R10", "reset outputs idle", {busy, done, error}, 0);
    check(spi_cs_n && !spi_sclk, "R7", "reset bus idle", {spi_cs_n, spi_sclk}, 2);
    check(!wd_ready && !rd_valid, "R11", "reset streams idle", {wd_ready, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 13; v++) begin
      automatic bit wr = VEC[v][33];
      automatic int a = int'(VEC[v][32:21]);
      automatic int len = int'(VEC[v][20:9]);
      automatic int ncmd = int'(VEC[v][8:1]);
      automatic bit er = VEC[v][0];
      automatic int nf, exp_a, bad_cmd, bad_addr, bad_zero, bad_data;
      run(wr, a, len, v);
      nf = nframes - r_f0;
      check(nf == ncmd, "R2", $sformatf("vector %0d command count", v), nf, ncmd);
      check(r_err == int'(er), "R8", $sformatf("vector %0d error flag", v), r_err, er);
      exp_a = a;
      bad_cmd = 0;
      bad_addr = 0;
      bad_zero = 0;
      for (int k = 0; k < nf && k < 16; k++) begin
        automatic int ix = (r_f0 + k) % 16;
        automatic logic [7:0] c = log_cmd[ix];
        automatic int l = log_len[ix];
        if (c[7:3] != 0 || c[0] != wr) bad_cmd++;
        else if (c[2:1] == 2'd0 && l != 2) bad_cmd++;
        else if (c[2:1] == 2'd1 && l != 4) bad_cmd++;
        else if (c[2:1] == 2'd2 && (l % 8 != 0 || l < 8 || l > 240)) bad_cmd++;
        else if (c[2:1] == 2'd3) bad_cmd++;
        if (log_addr[ix] != 32'(exp_a)) bad_addr++;
        if (!log_zok[ix]) bad_zero++;
        exp_a += l;
      end
      check(bad_cmd == 0, "R1", $sformatf("vector %0d command bytes", v), bad_cmd, 0);
      check(bad_addr == 0, "R3", $sformatf("vector %0d chunk addresses", v), bad_addr, 0);
      check(bad_zero == 0, wr ? "R5" : "R4", $sformatf("vector %0d idle bytes", v),
            bad_zero, 0);
      if (!er && len > 0) begin
        bad_data = 0;
        if (wr) begin
          for (int i = 0; i < len; i++) if (mem[a + i] != txpat(v, i)) bad_data++;
          check(bad_data == 0, "R6", $sformatf("vector %0d stored data", v), bad_data, 0);
          check(r_ti == len, "R9", $sformatf("vector %0d bytes taken", v), r_ti, len);
          if (len % 2 == 1)
            check(mem[a + len] == 8'h00, "R9", $sformatf("vector %0d pad byte", v),
                  mem[a + len], 0);
        end else begin
          for (int i = 0; i < len; i++) if (rxcap[i] != mem[a + i]) bad_data++;
          check(bad_data == 0, "R11", $sformatf("vector %0d read data order", v),
                bad_data, 0);
          check(r_rc == len, "R11", $sformatf("vector %0d read count", v), r_rc, len);
        end
      end
    end

    // R6: wire order of a 16-byte burst write
    run(1'b1, 32'h100, 16, 20);
    check(frame[5] == txpat(20, 7), "R6", "burst wire byte 0", frame[5], txpat(20, 7));
    check(frame[12] == txpat(20, 0), "R6", "burst wire byte 7", frame[12], txpat(20, 0));
    check(frame[13] == txpat(20, 15), "R6", "burst wire byte 8", frame[13], txpat(20, 15));
    check(last_bi == 22, "R5", "write frame length", last_bi, 22);

    // R2: exact chunk chain for the 260-byte read at low bits 2
    run(1'b0, 32'h002, 260, 21);
    begin
      automatic int exp_len [6] = '{2, 4, 240, 8, 4, 2};
      automatic int exp_cmd [6] = '{0, 2, 4, 4, 2, 0};
      for (int k = 0; k < 6; k++) begin
        automatic int ix = (r_f0 + k) % 16;
        check(log_len[ix] == exp_len[k], "R2", $sformatf("chunk %0d length", k),
              log_len[ix], exp_len[k]);
        check(int'(log_cmd[ix]) == exp_cmd[k], "R1", $sformatf("chunk %0d code", k),
              log_cmd[ix], exp_cmd[k]);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule